// File: doc/BRIEF.md
# Lane-Crossing Token Terrain and Collision Controller

This block follows the player token of a lane-crossing game as it hops between a safe meadow, a traffic lane and a water lane. Each clock cycle it receives colour codes sampled under the token's footprint. One set holds the scenery layer and the other holds the moving-sprite layer. It also receives the token's row index. From these it decides whether the token is still alive, is riding a floating log, has been killed, or has reached the far bank.

After a death or a victory, the controller holds its result for a fixed number of clock ticks. At the end of that hold it asks the rest of the game to put the token back at its start position. A victory also raises a one-cycle pulse at that moment, which a scorekeeper can count.

The controller is a Mealy machine. The on-log flag, the return request and the victory pulse follow the current inputs and the hold counter combinationally. The zone itself is registered.

Top module: `frog_terrain_fsm`

## Requirements
- R1: Colour codes are 2 bits per sample: 0 black, 1 green, 2 blue, 3 brown; sample i sits at bits [2i+1:2i]. The `zone_o` codes are 0 meadow, 1 road, 2 river, 3 dead, 4 won. While `rst_n` is low at a clock edge, the zone becomes meadow and the hold counter clears. In meadow, `dead_o`, `on_log_o`, `win_pulse_o` and `reset_req_o` are all 0.
- R2: From meadow, the zone moves to road when every scenery sample is black, and to river when every scenery sample is blue.
- R3: In road, the zone moves to dead when any sprite sample is not black. Otherwise it moves to meadow when every scenery sample is green.
- R4: `on_log_o` is 1 exactly when the zone is river and at least one sprite sample is brown, in the same cycle.
- R5: In river, the zone moves to dead when every sprite sample is black.
- R6: In river, when no death or win applies, any black scenery sample moves the zone to road. Failing that, all-green scenery moves it to meadow.
- R7: In meadow or river, a green sprite sample while `row_i` is 0 moves the zone to won.
- R8: Priority is death first, then win, then terrain moves. A green sprite on the road therefore kills the token.
- R9: On entering dead, `dead_o` stays 1 for exactly HOLD_TICKS cycles, and all inputs are ignored during that time. `reset_req_o` is 1 only in the last of those cycles. The zone is meadow in the following cycle.
- R10: In won, the zone holds for HOLD_TICKS cycles. In the last of those cycles, `win_pulse_o` and `reset_req_o` are both 1, and the zone then returns to meadow.
- R11: The hold counter restarts on every entry to dead or won, so a second hold lasts as long as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bg_px_i | input | 2*NSAMP | Scenery colour codes under the token |
| obj_px_i | input | 2*NSAMP | Sprite colour codes under the token |
| row_i | input | ROW_W | Token row index, 0 is the far bank |
| zone_o | output | 3 | Current zone code |
| dead_o | output | 1 | Token is in the death hold |
| on_log_o | output | 1 | Token rides a log this cycle |
| win_pulse_o | output | 1 | One-cycle victory pulse |
| reset_req_o | output | 1 | Return token to start position |

## Verification
The bench builds the block with NSAMP = 2, ROW_W = 3 and HOLD_TICKS = 5. Two samples of two bits make the scenery and sprite spaces 16 codes each, so every scenery/sprite pairing is swept from each live zone at row 0 and row 1. That sweep covers every priority collision and every all-versus-any boundary. The five-tick hold lets the bench count the whole death and win windows cycle by cycle, including a repeated death that exercises the counter restart.

// File: rtl/frog_pkg.sv
// Shared types for the terrain controller.
// Assumes 2-bit colour codes; the zone encoding is visible on the top port.
package frog_pkg;

    typedef enum logic [1:0] {
        COL_BLACK = 2'd0,
        COL_GREEN = 2'd1,
        COL_BLUE  = 2'd2,
        COL_BROWN = 2'd3
    } colour_t;

    typedef enum logic [2:0] {
        Z_MEADOW = 3'd0,
        Z_ROAD   = 3'd1,
        Z_RIVER  = 3'd2,
        Z_DEAD   = 3'd3,
        Z_WON    = 3'd4
    } zone_t;

    // Reduced view of the footprint samples.
    typedef struct packed {
        logic bg_all_black;
        logic bg_all_blue;
        logic bg_all_green;
        logic bg_any_black;
        logic obj_all_black;
        logic obj_any_brown;
        logic obj_any_green;
    } sense_t;

endpackage

// File: rtl/colour_sense.sv
// Classifies the footprint samples into all/any flags.
// Purely combinational; assumes NSAMP >= 1 and 2-bit codes.
module colour_sense
    import frog_pkg::*;
#(
    parameter int NSAMP = 4
) (
    input  logic [2*NSAMP-1:0] bg_px_i,
    input  logic [2*NSAMP-1:0] obj_px_i,
    output sense_t             sense_o
);

    logic [NSAMP-1:0] bg_blk, bg_blu, bg_grn;
    logic [NSAMP-1:0] ob_blk, ob_brn, ob_grn;

    // One comparator set per footprint sample.
    for (genvar i = 0; i < NSAMP; i++) begin : g_px
        assign bg_blk[i] = (bg_px_i[2*i +: 2]  == COL_BLACK);
        assign bg_blu[i] = (bg_px_i[2*i +: 2]  == COL_BLUE);
        assign bg_grn[i] = (bg_px_i[2*i +: 2]  == COL_GREEN);
        assign ob_blk[i] = (obj_px_i[2*i +: 2] == COL_BLACK);
        assign ob_brn[i] = (obj_px_i[2*i +: 2] == COL_BROWN);
        assign ob_grn[i] = (obj_px_i[2*i +: 2] == COL_GREEN);
    end

    // Reduce per-sample matches to the flags the controller uses.
    always_comb begin
        sense_o.bg_all_black  = &bg_blk;
        sense_o.bg_all_blue   = &bg_blu;
        sense_o.bg_all_green  = &bg_grn;
        sense_o.bg_any_black  = |bg_blk;
        sense_o.obj_all_black = &ob_blk;
        sense_o.obj_any_brown = |ob_brn;
        sense_o.obj_any_green = |ob_grn;
    end

endmodule

// File: rtl/hold_timer.sv
// Counts clock ticks while run_i is high and flags the final tick.
// Clears whenever run_i is low or the window expires, so each entry
// starts from zero. Assumes HOLD_TICKS >= 2.
module hold_timer #(
    parameter int HOLD_TICKS = 150_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);

    localparam int CNT_W = $clog2(HOLD_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    // Tick counter with clear on idle or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || expire_o) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                          // R9
    AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> cnt_q == '0);                           // R11

endmodule

// File: rtl/zone_step.sv
// Next-zone decision: death, then win, then terrain moves.
// Combinational; the hold zones leave only on timer expiry.
module zone_step
    import frog_pkg::*;
(
    input  zone_t  zone_i,
    input  sense_t sense_i,
    input  logic   row_top_i,
    input  logic   expire_i,
    output zone_t  zone_o
);

    logic win_hit;
    assign win_hit = sense_i.obj_any_green && row_top_i;

    // Prioritised transition selection per zone.
    always_comb begin
        zone_o = zone_i;
        unique case (zone_i)
            Z_MEADOW: begin
                if (win_hit)                   zone_o = Z_WON;
                else if (sense_i.bg_all_black) zone_o = Z_ROAD;
                else if (sense_i.bg_all_blue)  zone_o = Z_RIVER;
            end
            Z_ROAD: begin
                if (!sense_i.obj_all_black)    zone_o = Z_DEAD;
                else if (win_hit)              zone_o = Z_WON;
                else if (sense_i.bg_all_green) zone_o = Z_MEADOW;
            end
            Z_RIVER: begin
                if (sense_i.obj_all_black)     zone_o = Z_DEAD;
                else if (win_hit)              zone_o = Z_WON;
                else if (sense_i.bg_any_black) zone_o = Z_ROAD;
                else if (sense_i.bg_all_green) zone_o = Z_MEADOW;
            end
            Z_DEAD, Z_WON: begin
                if (expire_i)                  zone_o = Z_MEADOW;
            end
            default:                           zone_o = Z_MEADOW;
        endcase
    end

endmodule

// File: rtl/frog_terrain_fsm.sv
// Terrain and collision controller for the player token.
// Samples arrive already aligned to the token footprint; reset is
// synchronous active-low; HOLD_TICKS sets the death/win hold length.
module frog_terrain_fsm
    import frog_pkg::*;
#(
    parameter int NSAMP      = 4,
    parameter int ROW_W      = 4,
    parameter int HOLD_TICKS = 150_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NSAMP-1:0] bg_px_i,
    input  logic [2*NSAMP-1:0] obj_px_i,
    input  logic [ROW_W-1:0]   row_i,
    output logic [2:0]         zone_o,
    output logic               dead_o,
    output logic               on_log_o,
    output logic               win_pulse_o,
    output logic               reset_req_o
);

    sense_t sense;
    zone_t  zone_q, zone_d;
    logic   holding, expire;

    colour_sense #(.NSAMP(NSAMP)) u_sense (
        .bg_px_i  (bg_px_i),
        .obj_px_i (obj_px_i),
        .sense_o  (sense)
    );

    assign holding = (zone_q == Z_DEAD) || (zone_q == Z_WON);

    hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (holding),
        .expire_o (expire)
    );

    zone_step u_step (
        .zone_i    (zone_q),
        .sense_i   (sense),
        .row_top_i (row_i == '0),
        .expire_i  (expire),
        .zone_o    (zone_d)
    );

    // Zone register.
    always_ff @(posedge clk) begin
        if (!rst_n) zone_q <= Z_MEADOW;
        else        zone_q <= zone_d;
    end

    // Output decode (Mealy on samples and timer).
    always_comb begin
        zone_o      = zone_q;
        dead_o      = (zone_q == Z_DEAD);
        on_log_o    = (zone_q == Z_RIVER) && sense.obj_any_brown;
        reset_req_o = expire;
        win_pulse_o = expire && (zone_q == Z_WON);
    end

    AST_RESET_MEADOW: assert property (@(posedge clk)
        !rst_n |=> zone_o == 3'd0);                              // R1
    AST_EXIT_MEADOW: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> zone_o == 3'd0);                         // R9
    AST_DEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_o && !reset_req_o) |=> dead_o);                    // R9
    AST_WIN_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        win_pulse_o |-> reset_req_o);                            // R10
    AST_LOG_IN_RIVER: assert property (@(posedge clk) disable iff (!rst_n)
        on_log_o |-> zone_o == 3'd2);                            // R4

endmodule

// File: tb/frog_terrain_fsm_tb.sv
module frog_terrain_fsm_tb;

    localparam int NS = 2;
    localparam int RW = 3;
    localparam int HT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*NS-1:0] bg = '0;
    logic [2*NS-1:0] obj = '0;
    logic [RW-1:0] row = 3'd1;
    logic [2:0]    zone;
    logic          dead, on_log, win_p, req;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    frog_terrain_fsm #(.NSAMP(NS), .ROW_W(RW), .HOLD_TICKS(HT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bg_px_i(bg), .obj_px_i(obj), .row_i(row),
        .zone_o(zone), .dead_o(dead), .on_log_o(on_log),
        .win_pulse_o(win_p), .reset_req_o(req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sample helpers: count codes equal to c in a 2-sample vector.
    function automatic int cnt_code(input logic [3:0] v, input int c);
        int n = 0;
        for (int i = 0; i < NS; i++) if (int'(v[2*i +: 2]) == c) n++;
        return n;
    endfunction

    function automatic int model_next(input int z, input logic [3:0] b,
                                      input logic [3:0] o, input int r);
        bit win = (cnt_code(o, 1) > 0) && (r == 0);
        case (z)
            0: begin
                if (win) return 4;
                if (cnt_code(b, 0) == NS) return 1;
                if (cnt_code(b, 2) == NS) return 2;
                return 0;
            end
            1: begin
                if (cnt_code(o, 0) != NS) return 3;
                if (win) return 4;
                if (cnt_code(b, 1) == NS) return 0;
                return 1;
            end
            default: begin
                if (cnt_code(o, 0) == NS) return 3;
                if (win) return 4;
                if (cnt_code(b, 0) > 0) return 1;
                if (cnt_code(b, 1) == NS) return 0;
                return 2;
            end
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bg = 4'b0000; obj = 4'b0000; row = 3'd1;
        step(); step();
        rst_n = 1'b1;
        bg = 4'b1111; obj = 4'b1111; row = 3'd1;
        #1;
    endtask

    task automatic go_zone(input int z);
        do_reset();
        if (z == 1) begin bg = 4'b0000; obj = 4'b0000; step(); end
        if (z == 2) begin bg = 4'b1010; obj = 4'b1111; step(); end
    endtask

    task automatic hold_window(input bit is_win);
        for (int k = 0; k < HT; k++) begin
            bg = 4'b0000; obj = 4'b0101; row = '0;   // would move if honoured
            #1;
            if (!is_win) check("R9 dead_o", dead, 1);
            else         check("R10 zone", zone, 4);
            check(is_win ? "R10 reset_req" : "R9 reset_req", req, k == HT-1);
            check(is_win ? "R10 win_pulse" : "R9 win_pulse", win_p, is_win && k == HT-1);
            step();
        end
        #1;
        check(is_win ? "R10 back" : "R9 back", zone, 0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 zone", zone, 0);
        check("R1 outs", {dead, on_log, win_p, req}, 0);

        // Reset dominates a would-be move.
        rst_n = 1'b0; bg = 4'b0000; step(); #1;
        check("R1 reset", zone, 0);
        rst_n = 1'b1;

        // Sweep every scenery/sprite pair from each live zone.
        for (int z = 0; z < 3; z++)
            for (int b = 0; b < 16; b++)
                for (int o = 0; o < 16; o++)
                    for (int r = 0; r < 2; r++) begin
                        int exp;
                        go_zone(z);
                        bg = 4'(b); obj = 4'(o); row = 3'(r);
                        #1;
                        check("R4 on_log", on_log, (z == 2) && cnt_code(4'(o), 3) > 0);
                        check("R8 no req", req, 0);
                        exp = model_next(z, 4'(b), 4'(o), r);
                        step(); #1;
                        if (z == 0)      check("R2 R7 meadow next", zone, exp);
                        else if (z == 1) check("R3 R8 road next", zone, exp);
                        else             check("R5 R6 R7 river next", zone, exp);
                    end

        // Death hold, twice in a row for the restart check.
        go_zone(1);
        obj = 4'b1100; step();
        hold_window(1'b0);
        bg = 4'b0000; obj = 4'b0000; row = 3'd1; step();
        obj = 4'b0011; step();
        hold_window(1'b0);
        check("R11 second hold", zone, 0);

        // Win hold from meadow.
        do_reset();
        obj = 4'b0100; row = '0; step(); #1;
        check("R7 won", zone, 4);
        hold_window(1'b1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule